// File: doc/BRIEF.md
# ADC Front-End Start-Up Sequencer

This block is an SPI master that takes a multichannel delta-sigma ADC front end from power-up into continuous conversion without any help from software. A one-cycle `go` pulse starts a fixed script. The block first waits out a power-on delay. It then sends a reset command, a command that leaves continuous-read mode and a command that halts conversion. Next it writes a block of configuration registers in one burst. It finishes by starting conversion and entering continuous-read mode.

Every command travels in its own chip-select frame. Frames are separated by a quiet gap with chip select high. The gap after the reset command is longer, so that the converter has time to finish its internal reset. The burst write takes its data bytes from a flat register image on an input port. The register at the start address comes from the lowest byte of that image.

Top module: `adc_init_seq`

## Requirements
- R1: While reset is held, and after it is released with no `go` pulse, `cs_n` is 1, `sclk` is 0, and `busy` and `done` are 0.
- R2: The first chip-select frame opens no earlier than `POR_CYCLES` clocks after the `go` pulse.
- R3: The run sends exactly six frames in this order. The single-byte frames carry, in order, 0x06 (reset), 0x11 (stop continuous read) and 0x0A (stop conversion). The burst frame follows as the fourth frame. The last two frames carry 0x08 (start conversion) and 0x10 (continuous read).
- R4: The burst frame is `NREG+2` bytes long. Its first byte is 0x40 OR `START_ADDR`. Its second byte is `NREG-1`. The remaining bytes are the image bytes, lowest first. Byte i is `reg_image[8i+7:8i]` and goes to register `START_ADDR+i`.
- R5: Bytes go out MSB first in SPI mode 1. `sclk` idles low, `mosi` changes only on a rising `sclk` edge, and `mosi` is stable across every falling edge.
- R6: Every high phase of `sclk` lasts exactly `HALF_SCLK` clocks. Every low phase inside a frame lasts at least `HALF_SCLK` clocks.
- R7: After the reset frame closes, `cs_n` stays high for at least `RESET_WAIT` clocks.
- R8: Every other gap between frames keeps `cs_n` high for at least `GUARD_CYCLES` clocks.
- R9: `busy` rises on the cycle after `go` is accepted. It stays high until the continuous-read frame closes, and it falls on the same edge on which `done` pulses high for exactly one cycle. `cs_n` is low only while `busy` is high.
- R10: A `go` pulse while `busy` is high has no effect: the script neither restarts nor adds frames.
- R11: `sclk` is low whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | One-cycle start pulse |
| reg_image | input | 8*NREG | Register values for the burst write, lowest address in the low byte |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | SPI data toward the converter |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High while the script runs |
| done | output | 1 | One-cycle pulse when the script completes |

## Verification
The bench builds the block with `HALF_SCLK=2`, `POR_CYCLES=40`, `RESET_WAIT=20`, `GUARD_CYCLES=6` and the full 25-register burst. With these values two whole scripts, each of about a thousand clocks, fit in a short run. This makes every frame boundary, the long gap after reset and the gap from `go` to the first frame directly measurable. The bench drives two different register images so that the burst payload is shown to follow the input. It also sends a stray `go` in the middle of the first run.

// File: rtl/adc_init_pkg.sv
package adc_init_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POR,
    S_SETUP,
    S_SHIFT,
    S_HOLD,
    S_GAP
  } seq_state_t;

  localparam int unsigned NUM_STEPS  = 6;
  localparam int unsigned BURST_STEP = 3;

  localparam logic [7:0] OP_RESET  = 8'h06;
  localparam logic [7:0] OP_SDATAC = 8'h11;
  localparam logic [7:0] OP_HALT   = 8'h0A;
  localparam logic [7:0] OP_START  = 8'h08;
  localparam logic [7:0] OP_RDATAC = 8'h10;
  localparam logic [7:0] OP_WRBASE = 8'h40;

  // opcode for a single-byte script step
  function automatic logic [7:0] step_opcode(input logic [2:0] step);
    case (step)
      3'd0:    return OP_RESET;
      3'd1:    return OP_SDATAC;
      3'd2:    return OP_HALT;
      3'd4:    return OP_START;
      3'd5:    return OP_RDATAC;
      default: return OP_WRBASE;
    endcase
  endfunction

  // number of bytes in the frame of a step
  function automatic int unsigned frame_bytes(input logic [2:0] step, input int unsigned nreg);
    return (step == 3'(BURST_STEP)) ? nreg + 2 : 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_mode1_tx.sv
module spi_mode1_tx #(
  parameter int unsigned HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done
);
  localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] half_q;
  logic [3:0]    edge_q;   // even: high phase, odd: low phase
  logic [7:0]    sh_q;
  wire           phase_end = (half_q == HW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0; edge_q <= '0; sh_q <= '0;
      sclk <= 1'b0; mosi <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          sh_q   <= din;
          mosi   <= din[7];
          sclk   <= 1'b1;
          half_q <= '0;
          edge_q <= '0;
        end
      end else if (!phase_end) begin
        half_q <= half_q + 1'b1;
      end else begin
        half_q <= '0;
        if (!edge_q[0]) begin
          sclk   <= 1'b0;
          edge_q <= edge_q + 1'b1;
        end else if (edge_q == 4'd15) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          sclk   <= 1'b1;
          mosi   <= sh_q[6];
          sh_q   <= {sh_q[6:0], 1'b0};
          edge_q <= edge_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq #(
  parameter int unsigned NREG         = 25,
  parameter int unsigned START_ADDR   = 1,
  parameter int unsigned HALF_SCLK    = 2,
  parameter int unsigned POR_CYCLES   = 1000,
  parameter int unsigned RESET_WAIT   = 200,
  parameter int unsigned GUARD_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [8*NREG-1:0] reg_image,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic              done
);
  import adc_init_pkg::*;

  localparam int unsigned IMG_W    = 8 * NREG;
  localparam int unsigned MAX_WAIT = max3(POR_CYCLES, RESET_WAIT, max3(GUARD_CYCLES, HALF_SCLK, 1));
  localparam int unsigned TW       = $clog2(MAX_WAIT + 1) + 1;
  localparam int unsigned BW       = $clog2(NREG + 3);

  seq_state_t    st_q;
  logic [2:0]    step_q;
  logic [BW-1:0] byte_q;     // index of the next byte to send
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          tx_start, tx_done, tx_busy;
  logic [7:0]    tx_byte;

  function automatic logic [7:0] script_byte(input logic [2:0] step, input logic [BW-1:0] idx,
                                             input logic [IMG_W-1:0] img);
    int unsigned k;
    if (step != 3'(BURST_STEP)) return step_opcode(step);
    if (idx == BW'(0)) return OP_WRBASE | 8'(START_ADDR);
    if (idx == BW'(1)) return 8'(NREG - 1);
    k = int'(idx) - 2;
    if (k >= NREG) return 8'h00;
    return img[k*8 +: 8];
  endfunction

  // named internal events, used by the bound checker
  wire frame_open = !cs_n;
  wire all_sent   = (byte_q == BW'(frame_bytes(step_q, NREG)));
  wire last_step  = (step_q == 3'(NUM_STEPS - 1));

  assign tx_byte = script_byte(step_q, byte_q, reg_image);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    tx_start = 1'b0;
    case (st_q)
      S_IDLE:  if (go) begin tmr_load = 1'b1; tmr_val = TW'(POR_CYCLES); end
      S_POR:   if (tmr_expired) begin tmr_load = 1'b1; tmr_val = TW'(HALF_SCLK); end
      S_SETUP: if (tmr_expired) tx_start = 1'b1;
      S_SHIFT: if (tx_done) begin
                 if (all_sent) begin tmr_load = 1'b1; tmr_val = TW'(HALF_SCLK); end
                 else tx_start = 1'b1;
               end
      S_HOLD:  if (tmr_expired && !last_step) begin
                 tmr_load = 1'b1;
                 tmr_val  = (step_q == 3'd0) ? TW'(RESET_WAIT) : TW'(GUARD_CYCLES);
               end
      S_GAP:   if (tmr_expired) begin tmr_load = 1'b1; tmr_val = TW'(HALF_SCLK); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; step_q <= '0; byte_q <= '0;
      cs_n <= 1'b1; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE:  if (go) begin busy <= 1'b1; step_q <= '0; st_q <= S_POR; end
        S_POR:   if (tmr_expired) begin cs_n <= 1'b0; byte_q <= '0; st_q <= S_SETUP; end
        S_SETUP: if (tmr_expired) begin byte_q <= byte_q + 1'b1; st_q <= S_SHIFT; end
        S_SHIFT: if (tx_done) begin
                   if (all_sent) st_q <= S_HOLD;
                   else byte_q <= byte_q + 1'b1;
                 end
        S_HOLD:  if (tmr_expired) begin
                   cs_n <= 1'b1;
                   if (last_step) begin busy <= 1'b0; done <= 1'b1; st_q <= S_IDLE; end
                   else st_q <= S_GAP;
                 end
        S_GAP:   if (tmr_expired) begin
                   step_q <= step_q + 1'b1; byte_q <= '0; cs_n <= 1'b0; st_q <= S_SETUP;
                 end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  spi_mode1_tx #(.HALF(HALF_SCLK)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .din(tx_byte),
    .sclk(sclk), .mosi(mosi), .busy(tx_busy), .done(tx_done)
  );
endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk #(
  parameter int unsigned HALF_SCLK = 2
) (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic frame_open
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= sclk ? hi_run + 1'b1 : '0;
  end

  a_r11_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  a_r5_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> $stable(mosi));
  a_r6_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == 16'(HALF_SCLK)));
  a_r9_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_frame_in_busy: assert property (@(posedge clk) disable iff (!rst_n) frame_open |-> busy);
  a_r10_go_ignored: assert property (@(posedge clk) disable iff (!rst_n) (busy && go && !done) |=> busy);
endmodule

bind adc_init_seq adc_init_seq_chk #(.HALF_SCLK(HALF_SCLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .busy(busy), .done(done), .frame_open(frame_open)
);

// File: tb/adc_init_seq_test.sv
module adc_init_seq_test;
  localparam int NREG  = 25;
  localparam int SADDR = 1;
  localparam int HALF  = 2;
  localparam int POR   = 40;
  localparam int RWAIT = 20;
  localparam int GUARD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [8*NREG-1:0] img = '0;
  logic sclk, mosi, cs_n, busy, done;

  int total = 0, bad = 0;
  int cyc = 0, go_stamp = 0, rise_stamp = 0;
  int frames_seen = 0, frame_in_run = 0, last_op = 0, hi_run = 0, bits = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [7:0] shreg = '0;
  logic [7:0] got[$];
  logic [7:0] exp_bytes[$];
  int exp_len[$];
  bit finished = 0;

  adc_init_seq #(.NREG(NREG), .START_ADDR(SADDR), .HALF_SCLK(HALF), .POR_CYCLES(POR),
                 .RESET_WAIT(RWAIT), .GUARD_CYCLES(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .reg_image(img), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .busy(busy), .done(done));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_frame(input logic [7:0] b);
    exp_bytes.push_back(b); exp_len.push_back(1);
  endtask

  // driver: expected script for the current image
  task automatic push_script();
    push_frame(8'h06); push_frame(8'h11); push_frame(8'h0A);
    exp_bytes.push_back(8'h40 | 8'(SADDR));
    exp_bytes.push_back(8'(NREG - 1));
    for (int i = 0; i < NREG; i++) exp_bytes.push_back(img[i*8 +: 8]);
    exp_len.push_back(NREG + 2);
    push_frame(8'h08); push_frame(8'h10);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk) hi_run++;
      else if (prev_sclk) begin
        chk(hi_run == HALF, "R6 sclk high length", hi_run, HALF);
        hi_run = 0;
      end
      if (cs_n) chk(!sclk, "R11 sclk low outside frame", sclk, 0);
      if (prev_sclk && !sclk && !cs_n) begin
        shreg = {shreg[6:0], mosi};
        bits++;
        if (bits == 8) begin got.push_back(shreg); bits = 0; end
      end
      if (prev_cs && !cs_n) begin
        got.delete(); bits = 0;
        if (frame_in_run == 0)
          chk(cyc - go_stamp >= POR, "R2 power-on wait", cyc - go_stamp, POR);
        else if (last_op == 8'h06)
          chk(cyc - rise_stamp >= RWAIT, "R7 gap after reset", cyc - rise_stamp, RWAIT);
        else
          chk(cyc - rise_stamp >= GUARD, "R8 guard gap", cyc - rise_stamp, GUARD);
      end
      if (!prev_cs && cs_n) begin
        int n;
        rise_stamp = cyc;
        frames_seen++;
        if (exp_len.size() == 0) begin
          chk(0, "R10 unexpected extra frame", frames_seen, 0);
        end else begin
          n = exp_len.pop_front();
          chk(got.size() == n, (n == 1) ? "R3 frame length" : "R4 burst length", got.size(), n);
          for (int i = 0; i < n; i++) begin
            logic [7:0] e, a;
            e = exp_bytes.pop_front();
            a = (i < got.size()) ? got[i] : 8'hxx;
            chk(a === e, (n == 1) ? "R3 opcode" : "R4 burst byte R5 order", a, e);
          end
          last_op = (got.size() > 0) ? int'(got[0]) : 0;
        end
        frame_in_run++;
      end
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic run_script(input bit stray_go);
    int t;
    push_script();
    frame_in_run = 0;
    @(negedge clk); go = 1'b1; go_stamp = cyc;
    @(negedge clk); go = 1'b0;
    chk(busy == 1'b1, "R9 busy after go", busy, 1);
    if (stray_go) begin
      repeat (200) @(negedge clk);
      go = 1'b1; @(negedge clk); go = 1'b0;
      chk(busy == 1'b1, "R10 busy kept on stray go", busy, 1);
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R9 done seen", done, 1);
    chk(busy == 1'b0, "R9 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
    chk(exp_len.size() == 0, "R3 all six frames seen", exp_len.size(), 0);
    chk(frame_in_run == 6, "R10 frame count per run", frame_in_run, 6);
    repeat (60) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R10 no restart after run", {cs_n, busy}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 idle after reset", {cs_n, busy, done}, 4);
    img = '0;
    img[0*8 +: 8] = 8'h86; img[1*8 +: 8] = 8'h10; img[2*8 +: 8] = 8'hC0; img[19*8 +: 8] = 8'hF0;
    run_script(1'b1);
    for (int i = 0; i < NREG; i++) img[i*8 +: 8] = 8'(i * 7 + 3);
    run_script(1'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule